// File: doc/BRIEF.md
# Posted Write Buffer with Hysteresis Backpressure

This block holds memory writes that could not be sent to the array at once. Each accepted write (address plus data) is placed in a circular store. Entries leave it oldest first, toward a downstream re-ordering stage, under a valid/ready handshake. A registered block signal tells the request source to stop sending writes. It rises when the buffer fills to a high mark and falls only after the fill has dropped below a lower mark. The gap between the two marks stops the signal from toggling on every cycle near the limit.

Once a write is posted it must look as if memory already holds it. To support this, the block has a combinational lookup port. It compares a read address against every live entry and returns the data of the most recently posted matching write. The rest of the read path sits outside this block.

Top module: `posted_write_buf`

## Requirements
- R1: After reset the buffer is empty: `wr_block` is 0, `deq_valid` is 0 and `lk_hit` is 0.
- R2: A write is accepted on a clock edge where `wr_valid` is 1 and `wr_block` is 0. A write offered while `wr_block` is 1 is dropped and never appears at the dequeue port.
- R3: `wr_block` is a register. It is 1 from the edge at which the fill becomes 60 entries (the high mark), so the fill never goes above 60.
- R4: Once set, `wr_block` stays 1 while the fill is 56 or more. It returns to 0 on the edge at which the fill becomes 55.
- R5: `deq_valid` is 1 exactly when at least one entry is held. `deq_addr`/`deq_data` show the oldest entry. That entry is removed on an edge with `deq_ready` at 1, so entries leave in the order they were accepted.
- R6: An accepted write and a dequeue on the same edge both take effect, and the fill count stays the same.
- R7: `lk_hit` is 1 in the same cycle when any held entry has an address equal to `lk_addr`. `lk_data` then carries that entry's data.
- R8: If several held entries match `lk_addr`, `lk_data` is the data of the most recently accepted one.
- R9: `deq_ready` asserted while the buffer is empty has no effect. Later dequeues still return writes in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A write is offered |
| wr_addr | input | ADDR_W | Address of the offered write |
| wr_data | input | DATA_W | Data of the offered write |
| wr_block | output | 1 | Registered backpressure; offered writes are refused while 1 |
| deq_valid | output | 1 | Oldest entry is present |
| deq_ready | input | 1 | Downstream takes the oldest entry |
| deq_addr | output | ADDR_W | Address of the oldest entry |
| deq_data | output | DATA_W | Data of the oldest entry |
| lk_addr | input | ADDR_W | Address of a read to check against posted writes |
| lk_hit | output | 1 | Some held entry matches `lk_addr` |
| lk_data | output | DATA_W | Data of the youngest matching entry |

## Verification
Two events can land on the same edge: a write is taken in and the oldest entry is released. Both can also happen while a lookup is matching the entry that is about to leave. The bench provokes this in long stretches with `wr_valid` and `deq_ready` both held high. One stretch runs at the 60-entry plateau and others run with random traffic over a small address set, which forces repeated addresses. A queue model in the bench applies the push and the pop of each edge together. Every cycle it compares the head entry, the block level and the youngest-match lookup result against the design.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } pwb_op_e;

    // Hysteresis: set at or above hi, clear below lo, otherwise hold.
    function automatic logic block_next(input int fill, input logic cur,
                                        input int hi, input int lo);
        if (fill >= hi)
            return 1'b1;
        else if (fill < lo)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HI    = 60,
    parameter int LO    = 56,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          deq_ready,
    output logic          push,
    output logic          pop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] fill,
    output logic          block
);

    pwb_op_e       op;
    logic [CW-1:0] fill_nx;

    assign push = wr_valid && !block && (fill != CW'(DEPTH));
    assign pop  = deq_ready && (fill != '0);
    assign op   = pwb_op_e'({push, pop});

    always_comb begin
        case (op)
            OP_PUSH: fill_nx = fill + CW'(1);
            OP_POP:  fill_nx = fill - CW'(1);
            default: fill_nx = fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            block  <= 1'b0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            fill  <= fill_nx;
            block <= block_next(int'(fill_nx), block, HI, LO);
        end
    end

endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PW-1:0]     wr_ptr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_ptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_all [DEPTH],
    output logic [DATA_W-1:0] data_all [DEPTH]
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (wr_ptr == PW'(g))) begin
                addr_q[g] <= wr_addr;
                data_q[g] <= wr_data;
            end
        end
        assign addr_all[g] = addr_q[g];
        assign data_all[g] = data_q[g];
    end

    assign rd_addr = addr_q[rd_ptr];
    assign rd_data = data_q[rd_ptr];

endmodule

// File: rtl/pwb_lookup.sv
module pwb_lookup #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0] addr_all [DEPTH],
    input  logic [DATA_W-1:0] data_all [DEPTH],
    input  logic [PW-1:0]     rd_ptr,
    input  logic [CW-1:0]     fill,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data
);

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int age = 0; age < DEPTH; age++) begin
            int slot;
            slot = int'(rd_ptr) + age;
            if (slot >= DEPTH)
                slot = slot - DEPTH;
            if ((age < int'(fill)) && (addr_all[slot] == lk_addr)) begin
                lk_hit  = 1'b1;
                lk_data = data_all[slot];
            end
        end
    end

endmodule

// File: rtl/posted_write_buf.sv
module posted_write_buf
    import pwb_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int HI_MARK = 60,
    parameter int LO_MARK = 56,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int PW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_block,
    output logic              deq_valid,
    input  logic              deq_ready,
    output logic [ADDR_W-1:0] deq_addr,
    output logic [DATA_W-1:0] deq_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data
);

    logic              push, pop;
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     occ;
    logic [ADDR_W-1:0] addr_all [DEPTH];
    logic [DATA_W-1:0] data_all [DEPTH];

    pwb_ctrl #(.DEPTH(DEPTH), .HI(HI_MARK), .LO(LO_MARK)) u_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .deq_ready(deq_ready),
        .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .fill(occ), .block(wr_block)
    );

    pwb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(push), .wr_ptr(wr_ptr), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_ptr(rd_ptr), .rd_addr(deq_addr),
        .rd_data(deq_data), .addr_all(addr_all), .data_all(data_all)
    );

    pwb_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_look (
        .addr_all(addr_all), .data_all(data_all), .rd_ptr(rd_ptr),
        .fill(occ), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    assign deq_valid = (occ != '0);

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int CW = 7,
    parameter int HI = 60,
    parameter int LO = 56
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          deq_ready,
    input logic          deq_valid,
    input logic          wr_block,
    input logic          lk_hit,
    input logic [CW-1:0] occ
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(HI));

    p_rise_at_high_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_block) |-> occ == CW'(HI));

    p_fall_below_low_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_block) |-> occ == CW'(LO - 1));

    p_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_block && !deq_ready) |=> occ == $past(occ));

    p_push_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_block && deq_ready && deq_valid) |=> occ == $past(occ));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (!deq_valid && !wr_valid) |=> !deq_valid);

    p_hit_needs_entry_r7: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> deq_valid);

endmodule

bind posted_write_buf pwb_checker #(.CW(CW), .HI(HI_MARK), .LO(LO_MARK)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .deq_ready(deq_ready),
    .deq_valid(deq_valid), .wr_block(wr_block), .lk_hit(lk_hit), .occ(occ)
);

// File: tb/sim_posted_write_buf.sv
module sim_posted_write_buf;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int HI = 60;
    localparam int LO = 56;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_block;
    logic          deq_valid;
    logic          deq_ready = 1'b0;
    logic [AW-1:0] deq_addr;
    logic [DW-1:0] deq_data;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference model
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];
    logic          mblk = 1'b0;

    always #5 clk = ~clk;

    posted_write_buf u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_block(wr_block), .deq_valid(deq_valid),
        .deq_ready(deq_ready), .deq_addr(deq_addr), .deq_data(deq_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model (called at negedge).
    task automatic compare_all();
        bit hit = 1'b0;
        logic [DW-1:0] hd = '0;
        check(wr_block == mblk, "R3 R4 R6 block", wr_block, mblk);
        check(deq_valid == (qa.size() > 0), "R5 R9 deq_valid", deq_valid, qa.size() > 0);
        if (qa.size() > 0) begin
            check(deq_addr == qa[0], "R5 R2 deq_addr", deq_addr, qa[0]);
            check(deq_data == qd[0], "R5 R2 deq_data", deq_data, qd[0]);
        end
        for (int i = 0; i < qa.size(); i++)
            if (qa[i] == lk_addr) begin
                hit = 1'b1;
                hd  = qd[i];
            end
        check(lk_hit == hit, "R7 lk_hit", lk_hit, hit);
        if (hit)
            check(lk_data == hd, "R8 lk_data", lk_data, hd);
    endtask

    // One cycle: check, drive, clock, update model.
    task automatic step(input int wr_pct, input int rd_pct, input int amax);
        bit acc, take;
        int n;
        @(negedge clk);
        compare_all();
        wr_valid  = ($urandom_range(0, 99) < wr_pct);
        wr_addr   = AW'($urandom_range(0, amax));
        wr_data   = $urandom;
        deq_ready = ($urandom_range(0, 99) < rd_pct);
        lk_addr   = AW'($urandom_range(0, amax));
        @(posedge clk);
        acc  = wr_valid && !mblk;
        take = deq_ready && (qa.size() > 0);
        if (take) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        if (acc) begin
            qa.push_back(wr_addr);
            qd.push_back(wr_data);
        end
        n = qa.size();
        if (n >= HI)     mblk = 1'b1;
        else if (n < LO) mblk = 1'b0;
    endtask

    task automatic run(input int cycles, input int wr_pct, input int rd_pct, input int amax);
        for (int c = 0; c < cycles; c++)
            step(wr_pct, rd_pct, amax);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(wr_block == 1'b0, "R1 block after reset", wr_block, 0);
        check(deq_valid == 1'b0, "R1 deq_valid after reset", deq_valid, 0);
        check(lk_hit == 1'b0, "R1 lk_hit after reset", lk_hit, 0);
        // R9: dequeue attempts on an empty buffer
        run(5, 0, 100, 7);
        // R3, R2: fill to the high mark, keep offering refused writes
        run(90, 100, 0, 7);
        check(qa.size() == HI, "R3 model plateau", qa.size(), HI);
        // R6 at plateau, then R4 drain past the low mark
        run(20, 100, 100, 7);
        run(10, 0, 100, 7);
        run(40, 100, 100, 7);
        // drain fully, then empty pops (R9)
        run(80, 0, 100, 7);
        run(5, 0, 100, 7);
        // mixed traffic, heavy duplicates for R8
        run(2000, 50, 50, 3);
        run(2000, 80, 30, 7);
        run(1500, 40, 60, 15);
        @(negedge clk);
        compare_all();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule